// File: doc/BRIEF.md
# Shared Cache Way Shrink Governor

This block decides how many ways of a shared second-level cache stay powered while a two-core package moves between active, light idle and deep idle states. It keeps a count of active ways. Ways are always enabled from index 0 upward, so the enable vector is a thermometer of that count. When both cores sit in deep idle, it removes ways a fixed number per cycle, or all at once when a core asks for the deepest state with the full-shrink hint. When the package deep state may be entered, it raises a permit output.

Ways come back through a fill sequencer. Each way gets a one-cycle invalidate pulse, and its enable bit follows. A wake from stop-clock brings back a small fixed number of ways. Full size returns in two cases. The first is an interrupt that arrives after a growth condition has been latched: a performance ratio above a programmable threshold, an expired active-state timer, or a light idle request. The second is a shrink-prevention sub-state on a deep request. In that case the permit is also blocked.

Top module: `l2_way_governor`

## Requirements
- R1: After a synchronous reset, all NUM_WAYS ways are enabled, the count equals NUM_WAYS, no invalidate is driven, the permit is low, and the threshold and active timer are zero.
- R2: Core state codes are 0 active, 1 to 3 light idle, and 4 to 7 deep, where 6 is the deepest. While both cores are deep, no prevention bit is set, no growth condition is latched and no fill is running, the count drops by STEP_WAYS (saturating at 0) on each clock, and way_en equals the thermometer of the count.
- R3: When stop_clk falls while the count is 0, the block fills ways up to WAKE_WAYS.
- R4: A fill invalidates each way with a one-hot pulse on way_inv[i] for one cycle. Bit i of way_en is set on the next clock. Ways are filled in ascending order.
- R5: pkg_deep_ok is high exactly when, at the previous clock, the next count was 0, both cores were deep and no prevention bit was set.
- R6: A set prevention bit on a deep-requesting core starts a fill to NUM_WAYS and keeps pkg_deep_ok low.
- R7: When both cores are deep and one core requests state 6 with hint low bits equal to 2, the count goes to 0 in a single clock, and pkg_deep_ok rises on that same clock.
- R8: A ratio request strictly above the threshold latches a growth condition, and a request equal to the threshold does not. A latched condition blocks shrinking. The next interrupt consumes it and fills to NUM_WAYS.
- R9: A light idle request (state 1 to 3) from either core latches a growth condition.
- R10: C0_LIMIT consecutive clocks with a core in state 0 latch a growth condition. An interrupt before that point has no effect.
- R11: An interrupt with no latched condition leaves the count and way_inv unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core0_cstate | input | 3 | Core 0 requested idle state code |
| core0_hint | input | 4 | Core 0 deepest-state hint |
| core0_hold | input | 1 | Core 0 shrink-prevention sub-state |
| core1_cstate | input | 3 | Core 1 requested idle state code |
| core1_hint | input | 4 | Core 1 deepest-state hint |
| core1_hold | input | 1 | Core 1 shrink-prevention sub-state |
| stop_clk | input | 1 | Package stop-clock level |
| irq | input | 1 | Interrupt event |
| ratio_vld | input | 1 | Performance ratio request strobe |
| ratio_req | input | RATIO_W | Requested performance ratio |
| thr_wr | input | 1 | Threshold write strobe |
| thr_data | input | RATIO_W | Threshold write value |
| way_en | output | NUM_WAYS | Way enables, thermometer of the count |
| way_inv | output | NUM_WAYS | One-cycle way invalidate pulses |
| way_count | output | CW | Active way count |
| pkg_deep_ok | output | 1 | Package deep state permit |

## Verification
All results are registered. A shrink, a full-hint collapse and the permit are visible one clock after the inputs are sampled. The first invalidate of a fill appears one clock after the triggering input, and each enable one clock after its invalidate. The stop-clock wake needs one clock with stop_clk high before the falling edge is seen. Inputs are driven just after a rising edge and outputs are sampled one time unit later, so each check counts edges exactly. Fills are followed way by way against arithmetic thermometer and one-hot values.

// File: rtl/l2wg_pkg.sv
package l2wg_pkg;
  typedef enum logic {SEQ_IDLE, SEQ_FILL} seq_state_t;
  localparam logic [2:0] CST_ACTIVE  = 3'd0;
  localparam logic [2:0] CST_DEEP    = 3'd4;
  localparam logic [2:0] CST_DEEPEST = 3'd6;
  localparam logic [3:0] HINT_FULL   = 4'd2;
endpackage

// File: rtl/l2wg_wake_monitor.sv
module l2wg_wake_monitor #(
  parameter int RATIO_W = 6,
  parameter int C0_LIMIT = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               thr_wr,
  input  logic [RATIO_W-1:0] thr_data,
  input  logic               ratio_vld,
  input  logic [RATIO_W-1:0] ratio_req,
  input  logic               any_active,
  input  logic               any_light,
  input  logic               consume,
  output logic               grow_arm
);
  localparam int TW = $clog2(C0_LIMIT) + 1;
  localparam logic [TW-1:0] TLAST = TW'(C0_LIMIT - 1);

  logic [RATIO_W-1:0] thr_q;
  logic [TW-1:0]      tmr_q;
  logic               arm_q;
  logic               expire;
  logic               set_arm;

  assign expire  = any_active && (tmr_q == TLAST);
  assign set_arm = expire || any_light || (ratio_vld && (ratio_req > thr_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q <= '0;
      tmr_q <= '0;
      arm_q <= 1'b0;
    end else begin
      if (thr_wr) thr_q <= thr_data;
      if (!any_active || expire) tmr_q <= '0;
      else                       tmr_q <= tmr_q + 1'b1;
      arm_q <= (arm_q && !consume) || set_arm;
    end
  end

  assign grow_arm = arm_q;

  p_arm_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (arm_q && !consume) |=> arm_q);
  p_light_arms_r9: assert property (@(posedge clk) disable iff (rst)
    any_light |=> arm_q);
endmodule

// File: rtl/l2wg_way_sequencer.sv
module l2wg_way_sequencer
  import l2wg_pkg::*;
#(
  parameter int NUM_WAYS  = 8,
  parameter int STEP_WAYS = 2,
  parameter int WAKE_WAYS = 2,
  parameter int CW        = $clog2(NUM_WAYS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_keep,
  input  logic                req_grow,
  input  logic                req_wake,
  input  logic                shrink_ok,
  input  logic                shrink_all,
  output logic                grow_taken,
  output logic [CW-1:0]       cnt_next,
  output logic [NUM_WAYS-1:0] way_en,
  output logic [NUM_WAYS-1:0] way_inv,
  output logic [CW-1:0]       way_count
);
  localparam logic [CW-1:0] FULL = CW'(NUM_WAYS);
  localparam logic [CW-1:0] STEP = CW'(STEP_WAYS);
  localparam logic [CW-1:0] WAKE = CW'(WAKE_WAYS);

  function automatic logic [NUM_WAYS-1:0] thermo(input logic [CW-1:0] c);
    logic [NUM_WAYS-1:0] t;
    for (int i = 0; i < NUM_WAYS; i++) t[i] = (CW'(i) < c);
    return t;
  endfunction

  function automatic logic [NUM_WAYS-1:0] pick(input logic [CW-1:0] idx);
    return NUM_WAYS'(1) << idx;
  endfunction

  seq_state_t          st_q, st_d;
  logic [CW-1:0]       cnt_q, cnt_d, tgt_q, tgt_d;
  logic [NUM_WAYS-1:0] en_q, en_d, inv_q, inv_d;
  logic                start;

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    tgt_d      = tgt_q;
    en_d       = en_q;
    inv_d      = '0;
    start      = 1'b0;
    grow_taken = 1'b0;
    case (st_q)
      SEQ_IDLE: begin
        grow_taken = req_grow;
        if ((req_keep || req_grow) && (cnt_q < FULL)) begin
          tgt_d = FULL;
          start = 1'b1;
        end else if (req_wake && (cnt_q == '0)) begin
          tgt_d = WAKE;
          start = 1'b1;
        end else if (shrink_ok && (cnt_q != '0)) begin
          if (shrink_all || (cnt_q <= STEP)) cnt_d = '0;
          else                               cnt_d = cnt_q - STEP;
          en_d = thermo(cnt_d);
        end
        if (start) begin
          st_d  = SEQ_FILL;
          inv_d = pick(cnt_q);
        end
      end
      default: begin
        en_d  = en_q | pick(cnt_q);
        cnt_d = cnt_q + 1'b1;
        if ((cnt_q + 1'b1) < tgt_q) inv_d = pick(cnt_q + 1'b1);
        else                        st_d  = SEQ_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= FULL;
      tgt_q <= FULL;
      en_q  <= '1;
      inv_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      tgt_q <= tgt_d;
      en_q  <= en_d;
      inv_q <= inv_d;
    end
  end

  assign cnt_next  = cnt_d;
  assign way_en    = en_q;
  assign way_inv   = inv_q;
  assign way_count = cnt_q;

  p_inv_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(inv_q));
  p_en_follows_inv_r4: assert property (@(posedge clk) disable iff (rst)
    (inv_q != '0) |=> ((en_q & $past(inv_q)) == $past(inv_q)));
  p_inv_on_disabled_r4: assert property (@(posedge clk) disable iff (rst)
    (inv_q & en_q) == '0);
  p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL);
endmodule

// File: rtl/l2_way_governor.sv
module l2_way_governor
  import l2wg_pkg::*;
#(
  parameter int NUM_WAYS  = 8,
  parameter int STEP_WAYS = 2,
  parameter int WAKE_WAYS = 2,
  parameter int RATIO_W   = 6,
  parameter int C0_LIMIT  = 64,
  parameter int CW        = $clog2(NUM_WAYS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          core0_cstate,
  input  logic [3:0]          core0_hint,
  input  logic                core0_hold,
  input  logic [2:0]          core1_cstate,
  input  logic [3:0]          core1_hint,
  input  logic                core1_hold,
  input  logic                stop_clk,
  input  logic                irq,
  input  logic                ratio_vld,
  input  logic [RATIO_W-1:0]  ratio_req,
  input  logic                thr_wr,
  input  logic [RATIO_W-1:0]  thr_data,
  output logic [NUM_WAYS-1:0] way_en,
  output logic [NUM_WAYS-1:0] way_inv,
  output logic [CW-1:0]       way_count,
  output logic                pkg_deep_ok
);
  localparam int NCORE = 2;

  logic [NCORE-1:0][2:0] cst;
  logic [NCORE-1:0][3:0] hint;
  logic [NCORE-1:0]      hold;
  logic [NCORE-1:0]      is_deep, is_light, is_active, is_full, is_keep;

  assign cst  = {core1_cstate, core0_cstate};
  assign hint = {core1_hint, core0_hint};
  assign hold = {core1_hold, core0_hold};

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    assign is_deep[c]   = (cst[c] >= CST_DEEP);
    assign is_active[c] = (cst[c] == CST_ACTIVE);
    assign is_light[c]  = !is_deep[c] && !is_active[c];
    assign is_full[c]   = (cst[c] == CST_DEEPEST) && (hint[c] == HINT_FULL);
    assign is_keep[c]   = is_deep[c] && hold[c];
  end

  logic all_deep, keep_any, stop_q, wake_evt, grow_arm, grow_taken, pkg_q;
  logic [CW-1:0] cnt_next;

  assign all_deep = &is_deep;
  assign keep_any = |is_keep;
  assign wake_evt = stop_q && !stop_clk;

  l2wg_wake_monitor #(.RATIO_W(RATIO_W), .C0_LIMIT(C0_LIMIT)) u_mon (
    .clk(clk), .rst(rst), .thr_wr(thr_wr), .thr_data(thr_data),
    .ratio_vld(ratio_vld), .ratio_req(ratio_req),
    .any_active(|is_active), .any_light(|is_light),
    .consume(grow_taken), .grow_arm(grow_arm));

  l2wg_way_sequencer #(.NUM_WAYS(NUM_WAYS), .STEP_WAYS(STEP_WAYS),
                       .WAKE_WAYS(WAKE_WAYS), .CW(CW)) u_seq (
    .clk(clk), .rst(rst), .req_keep(keep_any), .req_grow(irq && grow_arm),
    .req_wake(wake_evt), .shrink_ok(all_deep && !keep_any && !grow_arm),
    .shrink_all(|is_full), .grow_taken(grow_taken), .cnt_next(cnt_next),
    .way_en(way_en), .way_inv(way_inv), .way_count(way_count));

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q <= 1'b0;
      pkg_q  <= 1'b0;
    end else begin
      stop_q <= stop_clk;
      pkg_q  <= (cnt_next == '0) && all_deep && !keep_any;
    end
  end

  assign pkg_deep_ok = pkg_q;

  p_permit_empty_r5: assert property (@(posedge clk) disable iff (rst)
    pkg_q |-> (way_count == '0));
  p_keep_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    keep_any |=> !pkg_q);
endmodule

// File: tb/tb_l2_way_governor.sv
module tb_l2_way_governor;
  localparam int N = 8;
  localparam int LIM = 16;

  logic clk = 0, rst = 1;
  logic [2:0] c0s = 4, c1s = 4;
  logic [3:0] c0h = 0, c1h = 0;
  logic c0k = 0, c1k = 0, stp = 0, irq = 0, rv = 0, tw = 0;
  logic [5:0] rr = 0, td = 0;
  logic [N-1:0] way_en, way_inv;
  logic [3:0] way_count;
  logic pkg_deep_ok;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  l2_way_governor #(.NUM_WAYS(N), .STEP_WAYS(2), .WAKE_WAYS(2), .RATIO_W(6),
                    .C0_LIMIT(LIM)) dut (
    .clk(clk), .rst(rst), .core0_cstate(c0s), .core0_hint(c0h), .core0_hold(c0k),
    .core1_cstate(c1s), .core1_hint(c1h), .core1_hold(c1k), .stop_clk(stp),
    .irq(irq), .ratio_vld(rv), .ratio_req(rr), .thr_wr(tw), .thr_data(td),
    .way_en(way_en), .way_inv(way_inv), .way_count(way_count),
    .pkg_deep_ok(pkg_deep_ok));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic see(string req, int cnt, int inv);
    chk({req, " count"}, way_count, cnt);
    chk({req, " en"}, way_en, (1 << cnt) - 1);
    chk({req, " inv"}, way_inv, inv);
  endtask

  task automatic fill_to_full(string req);
    for (int i = 1; i <= N; i++) begin
      step();
      see(req, i, (i < N) ? (1 << i) : 0);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(); step(); step();
    see("R1 reset", N, 0);
    chk("R1 permit", pkg_deep_ok, 0);
    rst = 0;
    // R2: stepwise shrink by two
    for (int c = N - 2; c >= 0; c -= 2) begin
      step();
      see("R2 shrink", c, 0);
      chk("R5 permit", pkg_deep_ok, (c == 0) ? 1 : 0);
    end
    step(); see("R2 hold zero", 0, 0);
    // R3: wake after stop-clock
    stp = 1; step();
    stp = 0; c0s = 0; step();
    see("R3 wake inv", 0, 1);
    step(); see("R4 wake way0", 1, 2);
    step(); see("R3 wake two", 2, 0);
    chk("R5 permit low", pkg_deep_ok, 0);
    step(); see("R3 stays two", 2, 0);
    c0s = 4; step();
    see("R2 reshrink", 0, 0);
    chk("R5 permit", pkg_deep_ok, 1);
    // R6: prevention sub-state
    c0k = 1; step();
    see("R6 start", 0, 1);
    chk("R6 permit", pkg_deep_ok, 0);
    fill_to_full("R6 fill");
    step(); see("R6 held full", N, 0);
    chk("R6 permit held", pkg_deep_ok, 0);
    // R7: full hint
    c0k = 0; c0s = 6; c0h = 2; c1s = 6; step();
    see("R7 one step", 0, 0);
    chk("R7 permit", pkg_deep_ok, 1);
    // R8 / R11: ratio threshold
    tw = 1; td = 10; step(); tw = 0;
    rv = 1; rr = 10; step(); rv = 0;
    irq = 1; step(); irq = 0;
    see("R11 equal ratio", 0, 0);
    step(); see("R11 no fill", 0, 0);
    rv = 1; rr = 11; step(); rv = 0;
    irq = 1; step(); irq = 0;
    see("R8 grow start", 0, 1);
    fill_to_full("R8 fill");
    step(); see("R7 after consume", 0, 0);
    // R9: light idle
    c1s = 2; step(); c1s = 6; step();
    irq = 1; step(); irq = 0;
    see("R9 grow start", 0, 1);
    fill_to_full("R9 fill");
    step(); see("R9 reshrink", 0, 0);
    // R10: active timer
    c0s = 0; c1s = 0; c0h = 0;
    for (int i = 0; i < LIM / 2; i++) step();
    irq = 1; step(); irq = 0;
    see("R10 early irq", 0, 0);
    for (int i = 0; i < LIM; i++) step();
    irq = 1; step(); irq = 0;
    see("R10 grow start", 0, 1);
    fill_to_full("R10 fill");
    // R8: armed state blocks shrink
    rv = 1; rr = 20; step(); rv = 0;
    c0s = 4; c1s = 4;
    for (int i = 0; i < 3; i++) begin
      step(); see("R8 blocked", N, 0);
    end
    irq = 1; step(); irq = 0;
    see("R8 consume at full", N, 0);
    step(); see("R8 shrink resumes", N - 2, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule